// File: doc/BRIEF.md
# Packet Category Counter

This block sits at the receive side of a packet stream and keeps a tally of what kind of logical-layer traffic arrives. On the first beat of each packet it reads the header byte, takes the format type and the transaction type, and sorts the packet into one of sixteen categories. These categories cover plain reads and writes, writes that expect a response, streaming writes, flow control, five kinds of maintenance traffic, data streaming, doorbells, messages, and three kinds of response. Each category has its own wrapping counter.

The stream side always accepts data. A small register port reads the counters back at 4-byte steps. Writing a 1 to bit 0 of the control word clears every counter together. Headers that match no category are dropped without a trace. Beats that are not the start of a packet are ignored.

Top module: `pkt_class_counter`

## Requirements
- R1: After reset every counter reads 0.
- R2: `st_ready` is 1 in every cycle after reset.
- R3: A beat with `st_valid` and `st_sop` both high is decoded with format type = `st_data[7:4]` and transaction type = `st_data[3:0]`. The matching counter rises by one at the next clock edge. The request categories and their read offsets are: ftype 2/ttype 4 at 0x04; ftype 5/ttype 4 at 0x08; ftype 5/ttype 5 at 0x0C; ftype 6 (any ttype) at 0x10; ftype 7 at 0x14; ftype 9 at 0x2C; ftype 10 at 0x30; ftype 11 at 0x34.
- R4: Format type 8 (maintenance) counts ttype 0, 1, 2, 3 and 4 at offsets 0x18, 0x1C, 0x20, 0x24 and 0x28.
- R5: Format type 13 (response) counts ttype 0 at 0x38, ttype 1 at 0x3C and ttype 8 at 0x40.
- R6: Any header that matches none of the combinations in R3 to R5 leaves every counter unchanged.
- R7: A beat with `st_sop` low leaves every counter unchanged, whatever its data.
- R8: A write to offset 0x00 with `csr_wdata[0]`=1 sets every counter to 0 at the next edge. A write there with bit 0 = 0 has no effect. Offset 0x00, and every offset above 0x40, reads 0.
- R9: When a clear and a counted beat fall in the same cycle, all counters read 0 afterwards.
- R10: Counters are `CNT_W` bits wide and wrap to 0 after their maximum value. Reads return them zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Stream beat valid |
| st_sop | input | 1 | Beat is the first of a packet |
| st_data | input | 8 | Header byte: format type in [7:4], transaction type in [3:0] |
| st_ready | output | 1 | Always 1 after reset |
| csr_addr | input | 8 | Byte offset of the register access |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data; bit 0 requests a clear at offset 0 |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |

## Verification
The bench sweeps all 256 header bytes as start beats. A decoder that mixed up the nibbles, or that let response ttype 8 or maintenance ttype 4 fall through, would leave a counter off from the computed tally. The same sweep with the start flag low finds a design that counts mid-packet beats. The bench narrows the counters to 8 bits and drives 260 packets into one category, which exposes a counter that saturates or does not wrap. It also lands a counted beat on the same edge as a clear, which catches a design that lets the increment win. A write of 0 to the control word and reads above the map confirm that neither one disturbs the counts or returns stale values.

// File: rtl/pkt_class_pkg.sv
package pkt_class_pkg;
    localparam int NUM_CAT = 16;

    // Category index; read offset is 4*(index+1)
    typedef enum logic [3:0] {
        C_RD_REQ   = 4'd0,
        C_WR       = 4'd1,
        C_WR_RSP   = 4'd2,
        C_STRM_WR  = 4'd3,
        C_FLOW     = 4'd4,
        C_MNT_RDQ  = 4'd5,
        C_MNT_WRQ  = 4'd6,
        C_MNT_RDR  = 4'd7,
        C_MNT_WRR  = 4'd8,
        C_MNT_PW   = 4'd9,
        C_DSTREAM  = 4'd10,
        C_BELL     = 4'd11,
        C_MSG      = 4'd12,
        C_RSP_NOPL = 4'd13,
        C_RSP_MSG  = 4'd14,
        C_RSP_PL   = 4'd15
    } cat_e;

    typedef struct packed {
        logic       known;
        cat_e       cat;
    } class_t;

    function automatic class_t classify(input logic [3:0] ft, input logic [3:0] tt);
        class_t r;
        r.known = 1'b1;
        r.cat   = C_RD_REQ;
        unique case (ft)
            4'd2:  if (tt == 4'd4) r.cat = C_RD_REQ; else r.known = 1'b0;
            4'd5:  begin
                if (tt == 4'd4)      r.cat = C_WR;
                else if (tt == 4'd5) r.cat = C_WR_RSP;
                else                 r.known = 1'b0;
            end
            4'd6:  r.cat = C_STRM_WR;
            4'd7:  r.cat = C_FLOW;
            4'd8:  begin
                unique case (tt)
                    4'd0: r.cat = C_MNT_RDQ;
                    4'd1: r.cat = C_MNT_WRQ;
                    4'd2: r.cat = C_MNT_RDR;
                    4'd3: r.cat = C_MNT_WRR;
                    4'd4: r.cat = C_MNT_PW;
                    default: r.known = 1'b0;
                endcase
            end
            4'd9:  r.cat = C_DSTREAM;
            4'd10: r.cat = C_BELL;
            4'd11: r.cat = C_MSG;
            4'd13: begin
                unique case (tt)
                    4'd0: r.cat = C_RSP_NOPL;
                    4'd1: r.cat = C_RSP_MSG;
                    4'd8: r.cat = C_RSP_PL;
                    default: r.known = 1'b0;
                endcase
            end
            default: r.known = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pkt_class_decode.sv
module pkt_class_decode
    import pkt_class_pkg::*;
#(
    parameter int N = NUM_CAT
) (
    input  logic         beat_valid,
    input  logic         beat_sop,
    input  logic [7:0]   hdr,
    output logic [N-1:0] hit
);
    class_t cls;

    always_comb begin
        cls = classify(hdr[7:4], hdr[3:0]);
        hit = '0;
        if (beat_valid && beat_sop && cls.known) begin
            hit[cls.cat] = 1'b1;
        end
    end
endmodule

// File: rtl/pkt_class_cnt_bank.sv
module pkt_class_cnt_bank #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        hit,
    input  logic                clr,
    output logic [N-1:0][W-1:0] cnt
);
    typedef struct packed {
        logic [N-1:0][W-1:0] cnt;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                state_d.cnt[i] = state_q.cnt[i] + W'(1);
            end
        end
        if (clr) begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt = state_q.cnt;
endmodule

// File: rtl/pkt_class_csr_rd.sv
module pkt_class_csr_rd #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic [N-1:0][W-1:0] cnt,
    input  logic [7:0]          addr,
    output logic [31:0]         rdata
);
    localparam int IDX_W = 6;
    logic [IDX_W-1:0] word;
    logic             unused_lsb;

    assign word       = addr[7:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (word == IDX_W'(i + 1)) begin
                rdata = 32'(cnt[i]);
            end
        end
    end
endmodule

// File: rtl/pkt_class_counter.sv
module pkt_class_counter
    import pkt_class_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        st_valid,
    input  logic        st_sop,
    input  logic [7:0]  st_data,
    output logic        st_ready,
    input  logic [7:0]  csr_addr,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata
);
    localparam int N = NUM_CAT;

    logic [N-1:0]            cat_hit;
    logic [N-1:0][CNT_W-1:0] cnt_all;
    logic                    clr_req;
    logic                    ready_q;
    logic                    unused_wbits;

    assign clr_req      = csr_wr && (csr_addr == 8'h00) && csr_wdata[0];
    assign unused_wbits = ^csr_wdata[31:1];

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end
    assign st_ready = ready_q | rst_n;

    pkt_class_decode #(.N(N)) u_dec (
        .beat_valid (st_valid),
        .beat_sop   (st_sop),
        .hdr        (st_data),
        .hit        (cat_hit)
    );

    pkt_class_cnt_bank #(.N(N), .W(CNT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cat_hit),
        .clr   (clr_req),
        .cnt   (cnt_all)
    );

    pkt_class_csr_rd #(.N(N), .W(CNT_W)) u_rd (
        .cnt   (cnt_all),
        .addr  (csr_addr),
        .rdata (csr_rdata)
    );
endmodule

// File: rtl/pkt_class_counter_chk.sv
module pkt_class_counter_chk #(
    parameter int N = 16,
    parameter int W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                st_valid,
    input logic                st_sop,
    input logic                st_ready,
    input logic                clr,
    input logic [N-1:0]        hit,
    input logic [N-1:0][W-1:0] cnt
);
    p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready);

    p_one_category_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    p_unknown_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_sop && hit == '0 && !clr) |=> $stable(cnt));

    p_mid_beat_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_sop && !clr) |=> $stable(cnt));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

bind pkt_class_counter pkt_class_counter_chk #(.N(N), .W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_sop   (st_sop),
    .st_ready (st_ready),
    .clr      (clr_req),
    .hit      (cat_hit),
    .cnt      (cnt_all)
);

// File: tb/pkt_class_counter_tb.sv
module pkt_class_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_sop = 1'b0;
    logic [7:0]  st_data = '0;
    logic        st_ready;
    logic [7:0]  csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int total = 0;
    int bad = 0;
    int exp_cnt [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_class_counter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_sop(st_sop),
        .st_data(st_data), .st_ready(st_ready), .csr_addr(csr_addr),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    // Category from the requirement tables; -1 when uncounted
    function automatic int cat_of(input logic [7:0] h);
        int f = int'(h[7:4]);
        int t = int'(h[3:0]);
        if (f == 2 && t == 4) return 0;
        if (f == 5 && t == 4) return 1;
        if (f == 5 && t == 5) return 2;
        if (f == 6) return 3;
        if (f == 7) return 4;
        if (f == 8 && t <= 4) return 5 + t;
        if (f == 9) return 10;
        if (f == 10) return 11;
        if (f == 11) return 12;
        if (f == 13 && t == 0) return 13;
        if (f == 13 && t == 1) return 14;
        if (f == 13 && t == 8) return 15;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic beat(input logic [7:0] h, input logic sop);
        @(negedge clk);
        st_valid = 1'b1;
        st_sop   = sop;
        st_data  = h;
        @(negedge clk);
        st_valid = 1'b0;
        st_sop   = 1'b0;
    endtask

    task automatic csr_write(input logic [31:0] d);
        @(negedge clk);
        csr_addr  = 8'h00;
        csr_wr    = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr    = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            rd(8'((i + 1) * 4), d);
            check(req, d, 32'(exp_cnt[i] % (1 << CW)));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 30000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 16; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset zero");
        check("R2 ready", 32'(st_ready), 32'd1);

        // R3 R4 R5 R6: every header byte as a start beat, twice for some
        for (int h = 0; h < 256; h++) begin
            beat(8'(h), 1'b1);
            if (cat_of(8'(h)) >= 0) exp_cnt[cat_of(8'(h))]++;
        end
        for (int h = 128; h < 224; h++) begin
            beat(8'(h), 1'b1);
            if (cat_of(8'(h)) >= 0) exp_cnt[cat_of(8'(h))]++;
        end
        check_all("R3/R4/R5/R6 sweep");
        check("R2 ready", 32'(st_ready), 32'd1);

        // R7: mid-packet beats change nothing
        for (int h = 0; h < 256; h++) beat(8'(h), 1'b0);
        check_all("R7 non-start beats");

        // R8: write of zero is ignored, reads outside the map give 0
        csr_write(32'hFFFF_FFFE);
        check_all("R8 bit0 clear ignored");
        rd(8'h00, d); check("R8 offset 0 reads zero", d, 32'd0);
        rd(8'h44, d); check("R8 above map reads zero", d, 32'd0);
        rd(8'hFC, d); check("R8 top offset reads zero", d, 32'd0);

        // R8: clear
        csr_write(32'h1);
        for (int i = 0; i < 16; i++) exp_cnt[i] = 0;
        check_all("R8 clear");

        // R9: clear and counted beat in the same cycle
        beat(8'h54, 1'b1);
        exp_cnt[1] = 1;
        @(negedge clk);
        st_valid = 1'b1; st_sop = 1'b1; st_data = 8'h54;
        csr_addr = 8'h00; csr_wr = 1'b1; csr_wdata = 32'h1;
        @(negedge clk);
        st_valid = 1'b0; st_sop = 1'b0; csr_wr = 1'b0;
        exp_cnt[1] = 0;
        check_all("R9 clear wins");

        // R10: wrap of an 8-bit counter
        for (int k = 0; k < 260; k++) beat(8'h24, 1'b1);
        rd(8'h04, d); check("R10 wrap", d, 32'd4);
        for (int k = 0; k < 255; k++) beat(8'hD8, 1'b1);
        rd(8'h40, d); check("R10 max value", d, 32'd255);
        beat(8'hD8, 1'b1);
        rd(8'h40, d); check("R10 wrap to zero", d, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule